// File: doc/BRIEF.md
# Stereo DC-Blocking High-Pass Filter

This block removes the DC offset from a pair of audio sample streams coming out of an analog-to-digital converter. Each channel, left and right, passes through its own first-order recursive high-pass section. A section subtracts the previous input from the current one and adds back a leaky copy of its previous output. The leak factor is one minus two to the minus eleventh. The corner therefore sits near fs/13000, about 3.4 Hz at 44.1 kHz, and it moves with the sample rate without any reprogramming.

Samples are 16-bit two's complement. Each channel carries its own valid strobe, and a result appears one clock after the sample that produced it. The converter's active-low power-down input wipes both channels' history. A synchronous active-high reset does the same. The first sample after a clear therefore leaves the block unchanged.

Top module: `dcblk_hpf`

## Requirements
- R1: While `rst` is high, and on the clock after it, both result ports read 0 and both result valids are low.
- R2: A result valid is high in exactly the cycle after its channel's input valid was high, and low otherwise.
- R3: The first sample a channel takes after a clear is output unchanged.
- R4: Per accepted sample, the accumulator A (signed, 12 fractional bits) becomes A + ((x - xp) * 4096) - (A >>> 11), where xp is the previous accepted input. The result is (A + 2048) >>> 12, saturated to 16 bits.
- R5: A result above +32767 is output as 16'h7FFF, and a result below -32768 is output as 16'h8000.
- R6: A constant input held for 30000 samples gives a result of exactly 0.
- R7: A strobe on one channel does not alter the other channel's result, valid or history. A channel's result holds between its own strobes.
- R8: One clock with `adc_pd_n` low clears both channels. On the next clock the results read 0 with their valids low, and the following first samples pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_pd_n | input | 1 | Converter power-down, active low; clears filter state |
| l_smp_i | input | 16 | Left input sample, two's complement |
| l_vld_i | input | 1 | Left input strobe |
| r_smp_i | input | 16 | Right input sample, two's complement |
| r_vld_i | input | 1 | Right input strobe |
| l_smp_o | output | 16 | Left filtered sample |
| l_vld_o | output | 1 | Left result valid |
| r_smp_o | output | 16 | Right filtered sample |
| r_vld_o | output | 1 | Right result valid |

## Verification
On every cycle, the assertions check the one-cycle valid relation and that a channel's result and accumulator hold when its strobe is idle. They also check that a first sample from a cleared state comes out unchanged, and that power-down empties both outputs. Only the bench scenarios can show that the arithmetic of each recursion step is exact. The same holds for clamping at both full-scale ends, for the slow decay of a held DC level all the way to zero, and for left and right staying separate under mixed strobe patterns.

// File: rtl/dcblk_pkg.sv
package dcblk_pkg;
  localparam int DCB_NCH = 2;
  typedef enum int unsigned {CH_LEFT = 0, CH_RIGHT = 1} dcb_chan_e;
endpackage

// File: rtl/dcblk_round_sat.sv
module dcblk_round_sat #(
  parameter int DW   = 16,
  parameter int FRAC = 12,
  parameter int AW   = 31
) (
  input  logic signed [AW-1:0] acc_i,
  output logic signed [DW-1:0] y_o
);
  localparam int QW = AW - FRAC + 1;
  localparam logic signed [AW:0]   HALF = (AW+1)'(2 ** (FRAC-1));
  localparam logic signed [QW-1:0] MAXV = QW'(2 ** (DW-1) - 1);
  localparam logic signed [QW-1:0] MINV = ~MAXV;

  logic signed [AW:0]   rnd;
  logic signed [QW-1:0] q;

  always_comb begin
    rnd = $signed({acc_i[AW-1], acc_i}) + HALF;
    q   = rnd[AW:FRAC];
    if (q > MAXV)      y_o = MAXV[DW-1:0];
    else if (q < MINV) y_o = MINV[DW-1:0];
    else               y_o = q[DW-1:0];
  end
endmodule

// File: rtl/dcblk_section.sv
module dcblk_section #(
  parameter int DW    = 16,
  parameter int FRAC  = 12,
  parameter int SHIFT = 11,
  parameter int GUARD = 3
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] x_i,
  output logic                 vld_o,
  output logic signed [DW-1:0] y_o
);
  localparam int AW = DW + GUARD + FRAC;

  logic signed [DW-1:0] x_prev_q;
  logic signed [AW-1:0] acc_q, acc_nx, fb, step;
  logic signed [DW:0]   diff;
  logic signed [DW-1:0] y_nx;

  always_comb begin
    diff   = $signed({x_i[DW-1], x_i}) - $signed({x_prev_q[DW-1], x_prev_q});
    step   = $signed({{(GUARD-1){diff[DW]}}, diff, {FRAC{1'b0}}});
    fb     = acc_q >>> SHIFT;
    acc_nx = acc_q - fb + step;
  end

  dcblk_round_sat #(.DW(DW), .FRAC(FRAC), .AW(AW)) u_rs (
    .acc_i (acc_nx),
    .y_o   (y_nx)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      x_prev_q <= '0;
      acc_q    <= '0;
      y_o      <= '0;
      vld_o    <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        x_prev_q <= x_i;
        acc_q    <= acc_nx;
        y_o      <= y_nx;
      end
    end
  end

  p_vld_follow_r2: assert property (@(posedge clk) disable iff (clr)
    vld_i |=> vld_o);
  p_vld_quiet_r2: assert property (@(posedge clk) disable iff (clr)
    !vld_i |=> !vld_o);
  p_first_pass_r3: assert property (@(posedge clk) disable iff (clr)
    (vld_i && x_prev_q == '0 && acc_q == '0) |=> (y_o == $past(x_i)));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (clr)
    !vld_i |=> ($stable(y_o) && $stable(acc_q)));
endmodule

// File: rtl/dcblk_hpf.sv
module dcblk_hpf
  import dcblk_pkg::*;
#(
  parameter int DW    = 16,
  parameter int FRAC  = 12,
  parameter int SHIFT = 11,
  parameter int GUARD = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adc_pd_n,
  input  logic signed [DW-1:0] l_smp_i,
  input  logic                 l_vld_i,
  input  logic signed [DW-1:0] r_smp_i,
  input  logic                 r_vld_i,
  output logic signed [DW-1:0] l_smp_o,
  output logic                 l_vld_o,
  output logic signed [DW-1:0] r_smp_o,
  output logic                 r_vld_o
);
  logic                 clr;
  logic signed [DW-1:0] smp_in  [DCB_NCH];
  logic signed [DW-1:0] smp_out [DCB_NCH];
  logic                 vld_in  [DCB_NCH];
  logic                 vld_out [DCB_NCH];

  assign clr = rst | ~adc_pd_n;

  assign smp_in[CH_LEFT]  = l_smp_i;
  assign smp_in[CH_RIGHT] = r_smp_i;
  assign vld_in[CH_LEFT]  = l_vld_i;
  assign vld_in[CH_RIGHT] = r_vld_i;

  for (genvar c = 0; c < DCB_NCH; c++) begin : g_ch
    dcblk_section #(.DW(DW), .FRAC(FRAC), .SHIFT(SHIFT), .GUARD(GUARD)) u_sec (
      .clk   (clk),
      .clr   (clr),
      .vld_i (vld_in[c]),
      .x_i   (smp_in[c]),
      .vld_o (vld_out[c]),
      .y_o   (smp_out[c])
    );
  end

  assign l_smp_o = smp_out[CH_LEFT];
  assign l_vld_o = vld_out[CH_LEFT];
  assign r_smp_o = smp_out[CH_RIGHT];
  assign r_vld_o = vld_out[CH_RIGHT];

  p_pd_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !adc_pd_n |=> (l_smp_o == '0 && r_smp_o == '0 && !l_vld_o && !r_vld_o));
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (l_smp_o == '0 && r_smp_o == '0 && !l_vld_o && !r_vld_o));
endmodule

// File: tb/dcblk_hpf_tb_top.sv
module dcblk_hpf_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adc_pd_n = 1'b1;
  logic signed [15:0] l_smp_i = '0, r_smp_i = '0;
  logic l_vld_i = 1'b0, r_vld_i = 1'b0;
  logic signed [15:0] l_smp_o, r_smp_o;
  logic l_vld_o, r_vld_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  longint m_acc [2];
  longint m_xp  [2];
  int     m_out [2];

  always #10 clk = ~clk;

  dcblk_hpf dut_i (
    .clk(clk), .rst(rst), .adc_pd_n(adc_pd_n),
    .l_smp_i(l_smp_i), .l_vld_i(l_vld_i),
    .r_smp_i(r_smp_i), .r_vld_i(r_vld_i),
    .l_smp_o(l_smp_o), .l_vld_o(l_vld_o),
    .r_smp_o(r_smp_o), .r_vld_o(r_vld_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_step(input int ch, input int x);
    longint q;
    m_acc[ch] = m_acc[ch] + (longint'(x) - m_xp[ch]) * 4096 - (m_acc[ch] >>> 11);
    m_xp[ch]  = x;
    q = (m_acc[ch] + 2048) >>> 12;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  task automatic model_clear();
    for (int c = 0; c < 2; c++) begin
      m_acc[c] = 0; m_xp[c] = 0; m_out[c] = 0;
    end
  endtask

  // call just after a negedge; returns just after the next negedge
  task automatic drive(input bit lv, input int lx, input bit rv, input int rx, input string req);
    l_vld_i = lv; l_smp_i = 16'(lx);
    r_vld_i = rv; r_smp_i = 16'(rx);
    if (lv) m_out[0] = model_step(0, lx);
    if (rv) m_out[1] = model_step(1, rx);
    @(negedge clk);
    l_vld_i = 1'b0; r_vld_i = 1'b0;
    chk({req, "/R2 lvld"}, l_vld_o, lv);
    chk({req, "/R2 rvld"}, r_vld_o, rv);
    chk({req, " lout"}, l_smp_o, m_out[0]);
    chk({req, " rout"}, r_smp_o, m_out[1]);
  endtask

  task automatic pd_pulse();
    adc_pd_n = 1'b0;
    @(negedge clk);
    adc_pd_n = 1'b1;
    model_clear();
    chk("R8 lout clr", l_smp_o, 0);
    chk("R8 rout clr", r_smp_o, 0);
    chk("R8 lvld clr", l_vld_o, 0);
    chk("R8 rvld clr", r_vld_o, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 lout", l_smp_o, 0);
    chk("R1 rout", r_smp_o, 0);
    chk("R1 lvld", l_vld_o, 0);
    chk("R1 rvld", r_vld_o, 0);
    rst = 1'b0;
    model_clear();
    @(negedge clk);
  endtask

  task automatic t_first_pass();
    drive(1, 1234, 1, -5000, "R3");
    chk("R3 left passthrough", l_smp_o, 1234);
    chk("R3 right passthrough", r_smp_o, -5000);
    drive(0, 0, 0, 0, "R2 idle");
  endtask

  task automatic t_sequence();
    logic [15:0] lf = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      drive(lf[3] | lf[7], int'($signed(lf)), lf[5], int'($signed({lf[7:0], lf[15:8]})), "R4");
    end
  endtask

  task automatic t_indep();
    pd_pulse();
    drive(1, 800, 0, 0, "R7");
    for (int i = 0; i < 5; i++) begin
      drive(0, 0, 1, 3000 * i - 7000, "R7");
      chk("R7 left held", l_smp_o, 800);
    end
    drive(1, 900, 0, 0, "R7");
  endtask

  task automatic t_sat();
    pd_pulse();
    drive(1, -32768, 1, 32767, "R5");
    drive(1, 32767, 1, -32768, "R5");
    chk("R5 clamp high", l_smp_o, 32767);
    chk("R5 clamp low", r_smp_o, -32768);
  endtask

  task automatic t_dc();
    pd_pulse();
    for (int i = 0; i < 30000; i++) drive(1, 20000, 1, -20000, "R6");
    chk("R6 left settled", l_smp_o, 0);
    chk("R6 right settled", r_smp_o, 0);
  endtask

  task automatic t_pd_mid();
    drive(1, 5000, 1, 6000, "R8");
    drive(1, -4000, 1, 100, "R8");
    pd_pulse();
    drive(1, -777, 1, 4242, "R8");
    chk("R8 left restart", l_smp_o, -777);
    chk("R8 right restart", r_smp_o, 4242);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_first_pass();
    t_sequence();
    t_indep();
    t_sat();
    t_pd_mid();
    t_dc();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule